// File: doc/BRIEF.md
# Word-then-byte split DMA engine

This engine copies one received data block of any byte length from a peripheral receive FIFO into system memory. It writes exactly the programmed number of bytes and never pads. Software builds two chained descriptors in memory. The first moves whole 32-bit words. The second is linked from the first and moves the leftover 0 to 3 bytes one at a time. A descriptor whose count is zero is passed over, so short blocks go straight to the byte phase. Blocks whose length is a multiple of four finish right after the word phase.

Software loads the first descriptor's address and a chunk-size code, then sets the enable bit. The engine fetches each descriptor, then waits for a data request from the peripheral. On each request it moves up to one chunk of beats and returns a one-cycle acknowledge. When a next pointer of zero ends the chain, the engine raises a done flag and drops the enable bit. A word-phase destination that is not word aligned raises an error flag instead.

Top module: `wbsplit_dma`

## Requirements
- R1: For a block of L bytes at destination D, bytes D..D+L-1 receive the FIFO bytes in FIFO order. No byte outside that range is written.
- R2: In a word descriptor (control bit 16 = 0), every beat pops one 32-bit FIFO word, little-endian. The beat is written with all four byte enables at a word-aligned address, and source and destination then advance by 4.
- R3: A descriptor with count (control bits [15:0]) equal to zero is skipped. It causes no FIFO pop and no memory write, and the engine goes on through its next pointer.
- R4: In a byte descriptor (control bit 16 = 1), every beat pops one byte from FIFO data bits [7:0]. The byte is written to the lane selected by address bits [1:0] with exactly one byte enable set, and source and destination then advance by 1.
- R5: A descriptor is four words at P, P+4, P+8 and P+12, in this order: source address, destination address, control, next pointer. A next pointer of zero ends the chain. The source address of each beat is presented on `per_addr`.
- R6: After each peripheral request the engine moves at most 2^C beats, where C is the chunk code at register 2. It then pulses `per_ack` for one cycle. The pulse also follows the last beat of a descriptor, even when that beat ends a partial chunk.
- R7: Writing 1 to bit 0 of register 0 while idle starts the engine from the pointer in register 1. Bit 0 reads 1 while the engine is active and clears itself at the end. A start written while active is ignored.
- R8: Register 3 reads done in bit 0 and error in bit 1. A read of register 3 returns the flags and clears them.
- R9: A word descriptor with a non-zero count and a destination not aligned to 4 sets the error flag and stops the engine. No pop and no write take place.
- R10: After reset the engine is idle. Registers 0 and 3 read zero, and no memory request, pop or acknowledge is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of register 3 clears the status) |
| reg_addr | input | 2 | Register index: 0 control, 1 descriptor pointer, 2 chunk code, 3 status |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_be | output | DATA_W/8 | Memory byte enables |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |
| per_dreq | input | 1 | Peripheral data request |
| per_pop | output | 1 | FIFO pop strobe |
| per_byte | output | 1 | The current pop is a single byte |
| per_addr | output | AW | Source address of the current beat |
| per_rdata | input | DATA_W | FIFO head data |
| per_ack | output | 1 | End-of-chunk acknowledge |

## Verification
Block lengths 1, 3, 4, 5, 7 and 512 are each run with every chunk code. Lengths 1 and 3 leave the word descriptor empty and exercise the skip. Length 4 leaves the byte descriptor empty. Lengths 5 and 7 use both phases, and 512 runs long word bursts. For every run, the bench compares the buffer against arithmetically generated FIFO bytes and checks that sentinel bytes on both sides of the buffer are unchanged. It also compares pop, write and acknowledge counts and the largest burst with values worked out from the length and chunk code. A misaligned word destination tells the error path apart from a skipped descriptor. A second start written mid-run would, if accepted, show up as corrupted data.

// File: rtl/wbsplit_pkg.sv
package wbsplit_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_FETCH,
      S_CHECK,
      S_WAITREQ,
      S_POP,
      S_WRITE,
      S_ACK,
      S_NEXT
   } wbsplit_state_e;

   localparam logic [1:0] REG_CTRL  = 2'd0;
   localparam logic [1:0] REG_DPTR  = 2'd1;
   localparam logic [1:0] REG_CHUNK = 2'd2;
   localparam logic [1:0] REG_STAT  = 2'd3;

   localparam int WIDTH_BIT = 16;

endpackage

// File: rtl/wbsplit_regs.sv
module wbsplit_regs import wbsplit_pkg::*; #(
   parameter int DATA_W  = 32,
   parameter int CHUNK_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [1:0]         reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic               active,
   input  logic               done_pulse,
   input  logic               err_pulse,
   output logic               start,
   output logic [DATA_W-1:0]  dptr,
   output logic [CHUNK_W-1:0] chunk,
   output logic               stat_done,
   output logic               stat_err
);

   logic stat_clr;

   assign start    = reg_wr && (reg_addr == REG_CTRL) && reg_wdata[0] && !active;
   assign stat_clr = reg_rd && (reg_addr == REG_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dptr      <= '0;
         chunk     <= '0;
         stat_done <= 1'b0;
         stat_err  <= 1'b0;
      end else begin
         if (reg_wr && !active && reg_addr == REG_DPTR)
            dptr <= reg_wdata;
         if (reg_wr && !active && reg_addr == REG_CHUNK)
            chunk <= reg_wdata[CHUNK_W-1:0];
         if (done_pulse)
            stat_done <= 1'b1;
         else if (stat_clr)
            stat_done <= 1'b0;
         if (err_pulse)
            stat_err <= 1'b1;
         else if (stat_clr)
            stat_err <= 1'b0;
      end
   end

   always_comb begin
      unique case (reg_addr)
         REG_CTRL:  reg_rdata = DATA_W'(active);
         REG_DPTR:  reg_rdata = dptr;
         REG_CHUNK: reg_rdata = DATA_W'(chunk);
         default:   reg_rdata = DATA_W'({stat_err, stat_done});
      endcase
   end

endmodule

// File: rtl/wbsplit_lane.sv
module wbsplit_lane #(
   parameter int DATA_W = 32
) (
   input  logic                  byte_mode,
   input  logic [$clog2(DATA_W/8)-1:0] addr_lo,
   input  logic [DATA_W-1:0]     word_in,
   output logic [DATA_W-1:0]     wdata,
   output logic [DATA_W/8-1:0]   be
);

   localparam int LANES = DATA_W / 8;
   localparam int LO_W  = $clog2(LANES);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign be[i]          = byte_mode ? (addr_lo == LO_W'(i)) : 1'b1;
      assign wdata[8*i +: 8] = byte_mode ? word_in[7:0] : word_in[8*i +: 8];
   end

endmodule

// File: rtl/wbsplit_dma.sv
module wbsplit_dma import wbsplit_pkg::*; #(
   parameter int AW      = 32,
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 16,
   parameter int CHUNK_W = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic                reg_rd,
   input  logic [1:0]          reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   output logic                mem_req,
   output logic                mem_we,
   output logic [AW-1:0]       mem_addr,
   output logic [DATA_W-1:0]   mem_wdata,
   output logic [DATA_W/8-1:0] mem_be,
   input  logic [DATA_W-1:0]   mem_rdata,
   input  logic                mem_ack,
   input  logic                per_dreq,
   output logic                per_pop,
   output logic                per_byte,
   output logic [AW-1:0]       per_addr,
   input  logic [DATA_W-1:0]   per_rdata,
   output logic                per_ack
);

   localparam int LANES  = DATA_W / 8;
   localparam int LO_W   = $clog2(LANES);
   localparam int BEAT_W = 1 << CHUNK_W;

   if (DATA_W != 32) begin : g_bad_data_w
      $error("wbsplit_dma: DATA_W must be 32");
   end
   if (AW > DATA_W || AW < 8) begin : g_bad_aw
      $error("wbsplit_dma: AW must be between 8 and DATA_W");
   end
   if (CNT_W < 1 || CNT_W > WIDTH_BIT) begin : g_bad_cnt_w
      $error("wbsplit_dma: CNT_W must fit below the width bit");
   end
   if (CHUNK_W < 1 || CHUNK_W > 3) begin : g_bad_chunk_w
      $error("wbsplit_dma: CHUNK_W must be 1 to 3");
   end

   wbsplit_state_e      st;
   logic [1:0]          fidx;
   logic [AW-1:0]       dptr_cur, src_q, dst_q, nxt_q;
   logic [CNT_W-1:0]    cnt_q;
   logic                byte_q;
   logic [BEAT_W-1:0]   beat_q, beat_lim;
   logic [DATA_W-1:0]   data_q;
   logic [DATA_W-1:0]   dptr_reg;
   logic [CHUNK_W-1:0]  chunk;
   logic                start, active, done_pulse, err_pulse, misalign;
   logic                stat_done, stat_err;
   logic [AW-1:0]       step;

   assign active     = (st != S_IDLE);
   assign misalign   = !byte_q && (dst_q[LO_W-1:0] != '0);
   assign done_pulse = (st == S_NEXT) && (nxt_q == '0);
   assign err_pulse  = (st == S_CHECK) && (cnt_q != '0) && misalign;
   assign step       = byte_q ? AW'(1) : AW'(LANES);
   assign beat_lim   = (BEAT_W'(1) << chunk) - BEAT_W'(1);

   assign mem_req  = (st == S_FETCH) || (st == S_WRITE);
   assign mem_we   = (st == S_WRITE);
   assign mem_addr = (st == S_FETCH) ? dptr_cur + (AW'(fidx) << 2) : dst_q;
   assign per_pop  = (st == S_POP);
   assign per_ack  = (st == S_ACK);
   assign per_byte = byte_q;
   assign per_addr = src_q;

   wbsplit_regs #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_rd     (reg_rd),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .active     (active),
      .done_pulse (done_pulse),
      .err_pulse  (err_pulse),
      .start      (start),
      .dptr       (dptr_reg),
      .chunk      (chunk),
      .stat_done  (stat_done),
      .stat_err   (stat_err)
   );

   wbsplit_lane #(.DATA_W(DATA_W)) u_lane (
      .byte_mode (byte_q),
      .addr_lo   (dst_q[LO_W-1:0]),
      .word_in   (data_q),
      .wdata     (mem_wdata),
      .be        (mem_be)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         fidx     <= '0;
         dptr_cur <= '0;
         src_q    <= '0;
         dst_q    <= '0;
         nxt_q    <= '0;
         cnt_q    <= '0;
         byte_q   <= 1'b0;
         beat_q   <= '0;
         data_q   <= '0;
      end else begin
         unique case (st)
            S_IDLE: begin
               if (start) begin
                  dptr_cur <= dptr_reg[AW-1:0];
                  fidx     <= '0;
                  st       <= S_FETCH;
               end
            end
            S_FETCH: begin
               if (mem_ack) begin
                  unique case (fidx)
                     2'd0: src_q <= mem_rdata[AW-1:0];
                     2'd1: dst_q <= mem_rdata[AW-1:0];
                     2'd2: begin
                        cnt_q  <= mem_rdata[CNT_W-1:0];
                        byte_q <= mem_rdata[WIDTH_BIT];
                     end
                     default: nxt_q <= mem_rdata[AW-1:0];
                  endcase
                  fidx <= fidx + 2'd1;
                  if (fidx == 2'd3)
                     st <= S_CHECK;
               end
            end
            S_CHECK: begin
               if (cnt_q == '0)
                  st <= S_NEXT;
               else if (misalign)
                  st <= S_IDLE;
               else begin
                  beat_q <= '0;
                  st     <= S_WAITREQ;
               end
            end
            S_WAITREQ: begin
               if (per_dreq)
                  st <= S_POP;
            end
            S_POP: begin
               data_q <= per_rdata;
               st     <= S_WRITE;
            end
            S_WRITE: begin
               if (mem_ack) begin
                  src_q  <= src_q + step;
                  dst_q  <= dst_q + step;
                  cnt_q  <= cnt_q - CNT_W'(1);
                  beat_q <= beat_q + BEAT_W'(1);
                  if (cnt_q == CNT_W'(1) || beat_q == beat_lim)
                     st <= S_ACK;
                  else
                     st <= S_POP;
               end
            end
            S_ACK: begin
               beat_q <= '0;
               st     <= (cnt_q == '0) ? S_NEXT : S_WAITREQ;
            end
            default: begin
               if (nxt_q == '0)
                  st <= S_IDLE;
               else begin
                  dptr_cur <= nxt_q;
                  fidx     <= '0;
                  st       <= S_FETCH;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/wbsplit_dma_chk.sv
module wbsplit_dma_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          active,
   input logic          mem_req,
   input logic          mem_we,
   input logic          mem_ack,
   input logic [AW-1:0] mem_addr,
   input logic [3:0]    mem_be,
   input logic          per_pop,
   input logic          per_ack,
   input logic          per_byte,
   input logic          stat_done,
   input logic          stat_err
);

   // R5: a request is held with a steady address until acknowledged
   assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   assert_word_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && !per_byte |-> mem_addr[1:0] == 2'b00 && mem_be == 4'hF);

   assert_byte_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && per_byte |-> $countones(mem_be) == 1 && mem_be[mem_addr[1:0]]);

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !mem_req && !per_pop && !per_ack);

   assert_single_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      per_pop |=> !per_pop && !per_ack);

   assert_done_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_done) |-> !active);

   assert_err_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_err) |-> !active);

endmodule

bind wbsplit_dma wbsplit_dma_chk #(.AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .active    (active),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_ack   (mem_ack),
   .mem_addr  (mem_addr),
   .mem_be    (mem_be),
   .per_pop   (per_pop),
   .per_ack   (per_ack),
   .per_byte  (per_byte),
   .stat_done (stat_done),
   .stat_err  (stat_err)
);

// File: tb/wbsplit_dma_test.sv
`timescale 1ns/1ps
module wbsplit_dma_test;

   localparam int MEMB = 2048;
   localparam logic [31:0] DESC_A   = 32'h100;
   localparam logic [31:0] DESC_B   = 32'h110;
   localparam logic [31:0] DST      = 32'h400;
   localparam logic [31:0] SRC_BASE = 32'h8000_0000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [3:0] mem_be;
   logic per_dreq, per_pop, per_byte, per_ack;
   logic [31:0] per_addr, per_rdata;

   logic [7:0] mem [0:MEMB-1];
   int rdptr, t_len, t_dst, seed;
   logic init_req = 1'b0;
   int wcount, ackcnt, popcnt, since, maxb, addr_err;
   int nerr = 0, nchecks = 0;

   always #2.5 clk = ~clk;

   wbsplit_dma uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata),
      .mem_ack(mem_ack), .per_dreq(per_dreq), .per_pop(per_pop),
      .per_byte(per_byte), .per_addr(per_addr), .per_rdata(per_rdata),
      .per_ack(per_ack)
   );

   function automatic logic [7:0] sbyte(int i, int s);
      return 8'((i * 37 + s * 11 + 5) & 255);
   endfunction

   assign per_dreq  = (rdptr < t_len);
   assign per_rdata = per_byte ? {24'h0, sbyte(rdptr, seed)} :
                      {sbyte(rdptr + 3, seed), sbyte(rdptr + 2, seed),
                       sbyte(rdptr + 1, seed), sbyte(rdptr, seed)};

   task automatic put_word(logic [31:0] a, logic [31:0] v);
      for (int k = 0; k < 4; k++) mem[(int'(a) + k) % MEMB] = v[8*k +: 8];
   endtask

   // memory model, FIFO model and activity counters
   always @(posedge clk) begin
      if (init_req) begin
         int w, b;
         w = t_len / 4;
         b = t_len % 4;
         for (int i = 0; i < MEMB; i++) mem[i] = 8'hA5;
         put_word(DESC_A, SRC_BASE);
         put_word(DESC_A + 4, 32'(t_dst));
         put_word(DESC_A + 8, 32'(w));
         put_word(DESC_A + 12, DESC_B);
         put_word(DESC_B, SRC_BASE + 32'(4 * w));
         put_word(DESC_B + 4, 32'(t_dst + 4 * w));
         put_word(DESC_B + 8, 32'h0001_0000 | 32'(b));
         put_word(DESC_B + 12, 32'h0);
         rdptr <= 0;
         mem_ack <= 1'b0;
         wcount = 0; ackcnt = 0; popcnt = 0; since = 0; maxb = 0; addr_err = 0;
      end else if (rst_n) begin
         if (mem_req && !mem_ack) begin
            int base;
            base = int'(mem_addr) % MEMB & ~3;
            mem_ack <= 1'b1;
            if (mem_we) begin
               for (int k = 0; k < 4; k++)
                  if (mem_be[k]) mem[base + k] = mem_wdata[8*k +: 8];
               wcount++;
            end else
               mem_rdata <= {mem[base + 3], mem[base + 2], mem[base + 1], mem[base]};
         end else
            mem_ack <= 1'b0;
         if (per_pop) begin
            if (per_addr != SRC_BASE + 32'(rdptr)) addr_err++;
            rdptr <= rdptr + (per_byte ? 1 : 4);
            popcnt++;
            since = since + 1;
            if (since > maxb) maxb = since;
         end
         if (per_ack) begin
            ackcnt++;
            since = 0;
         end
      end else begin
         mem_ack <= 1'b0;
         mem_rdata <= '0;
      end
   end

   task automatic chk(bit ok, string req, string what, int act, int exp);
      nchecks++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic reg_write(logic [1:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(logic [1:0] a, output int v);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 v = int'(reg_rdata);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic do_init(int len, int dst, int s);
      t_len = len; t_dst = dst; seed = s;
      @(negedge clk) init_req = 1'b1;
      @(negedge clk) init_req = 1'b0;
   endtask

   task automatic run(int len, int ch);
      int v, n, w, b, cb, bad_w, bad_b, guard, ack_exp;
      w = len / 4; b = len % 4; cb = 1 << ch;
      do_init(len, int'(DST), len + ch);
      reg_write(2'd1, DESC_A);
      reg_write(2'd2, 32'(ch));
      reg_write(2'd0, 32'd1);
      reg_read(2'd0, v);
      chk(v == 1, "R7", "enable reads back while active", v, 1);
      reg_write(2'd0, 32'd1);               // R7: ignored while active
      n = 0;
      do begin reg_read(2'd0, v); n++; end while (v != 0 && n < 20000);
      chk(n < 20000, "R7", "enable self-clears", v, 0);
      reg_read(2'd3, v);
      chk(v == 1, "R8", "status done", v, 1);
      reg_read(2'd3, v);
      chk(v == 0, "R8", "status cleared by read", v, 0);
      bad_w = 0; bad_b = 0; guard = 0;
      for (int i = 0; i < len; i++)
         if (mem[int'(DST) + i] != sbyte(i, len + ch)) begin
            if (i < 4 * w) bad_w++; else bad_b++;
         end
      for (int i = 1; i <= 16; i++) begin
         if (mem[int'(DST) - i] != 8'hA5) guard++;
         if (mem[int'(DST) + len - 1 + i] != 8'hA5) guard++;
      end
      chk(bad_w == 0, "R2", $sformatf("word data len=%0d ch=%0d", len, ch), bad_w, 0);
      chk(bad_b == 0, "R4", $sformatf("byte data len=%0d ch=%0d", len, ch), bad_b, 0);
      chk(guard == 0, "R1", $sformatf("bytes outside buffer len=%0d", len), guard, 0);
      chk(wcount == w + b, "R1", "memory write count", wcount, w + b);
      chk(popcnt == w + b, (w == 0 || b == 0) ? "R3" : "R2", "FIFO pop count", popcnt, w + b);
      ack_exp = (w + cb - 1) / cb + (b + cb - 1) / cb;
      chk(ackcnt == ack_exp, "R6", $sformatf("ack count ch=%0d", ch), ackcnt, ack_exp);
      chk(maxb <= cb, "R6", "largest burst", maxb, cb);
      chk(addr_err == 0, "R5", "source pointer from descriptors", addr_err, 0);
   endtask

   initial begin
      int v, lens[6];
      lens = '{1, 3, 4, 5, 7, 512};
      t_len = 0; t_dst = 0; seed = 0; rdptr = 0;
      repeat (3) @(negedge clk);
      chk(mem_req == 1'b0 && per_pop == 1'b0, "R10", "no activity in reset", int'(mem_req), 0);
      rst_n = 1'b1;
      reg_read(2'd0, v);
      chk(v == 0, "R10", "control after reset", v, 0);
      reg_read(2'd3, v);
      chk(v == 0, "R10", "status after reset", v, 0);
      for (int li = 0; li < 6; li++)
         for (int ch = 0; ch < 4; ch++)
            run(lens[li], ch);
      // R9: misaligned word destination
      do_init(8, int'(DST) + 2, 9);
      reg_write(2'd1, DESC_A);
      reg_write(2'd2, 32'd1);
      reg_write(2'd0, 32'd1);
      repeat (30) @(negedge clk);
      reg_read(2'd0, v);
      chk(v == 0, "R9", "engine stopped on misalignment", v, 0);
      reg_read(2'd3, v);
      chk(v == 2, "R9", "error flag", v, 2);
      chk(wcount == 0, "R9", "no write on misalignment", wcount, 0);
      chk(popcnt == 0, "R9", "no pop on misalignment", popcnt, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchecks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      nchecks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchecks);
      $finish;
   end

endmodule